// File: doc/BRIEF.md
# Measurement Data Package Transmitter

This block carries measurement results out to a host processor over an 8-bit parallel bus. The results go out as short packages rather than as one long stream. A reporting cycle is split into equal slots. The scheduler picks a fixed subset of those slots so that six packages are spread evenly across the cycle. Package numbers run 1 to 6 and then start again at 1.

Every package opens with a four-byte header, followed by an idle pause so the host can inspect the header. After the pause comes a list of 16-bit words. Each word is read from an external result store through a one-clock-latency read port and sent low byte first. In the raw-sample mode, the word list is replaced by a block of input samples held at the top of the same store.

A `pkg_rdy` level frames each package and a strobe marks each byte. The byte stays fixed on the bus for the whole byte period. A single `cycle_tick` pulse starts the schedule, and any later pulse realigns it to the first slot.

Top module: `meas_pkg_tx`

## Requirements
- R1: After reset, `bus_stb`, `pkg_rdy`, `rd_en` and `bus_data` are 0. No package starts until the first `cycle_tick` has been seen.
- R2: The clock edge that samples `cycle_tick` high starts package 1 at once, when the block is idle, and restarts the slot schedule at slot 0.
- R3: After a `cycle_tick`, slot s (0..SLOTS-1) begins SLOT_CLKS·s clocks later, and the schedule repeats on its own every SLOTS slots. A package starts at slot s only if r = (s·NUM_PKG) mod SLOTS is either 0 or greater than SLOTS−NUM_PKG. With 10 slots and 6 packages, packages start in slots 0, 1, 3, 5, 6 and 8.
- R4: `pkg_id` is the package number, in the range 1..NUM_PKG. It stays constant while `pkg_rdy` is high, goes up by one with each package, and wraps from NUM_PKG back to 1.
- R5: The header is sent in this order: 0xA5 (low byte of sync word 0xC3A5), then 0xC3, then the mode byte, then the status byte. Mode and status are captured on the edge that starts the package, so later changes to them do not affect that package.
- R6: In normal mode, package p carries REGS_PER_PKG words. Word j is read from address (p−1)·REGS_PER_PKG + j, and each word is sent low byte first.
- R7: When the captured mode byte equals 0x05, the package carries RAW_WORDS words instead. Word j is read from address NUM_PKG·REGS_PER_PKG + j, and each word is sent low byte first.
- R8: Each byte lasts BYTE_CLKS clocks. `bus_stb` is high for the first STB_HI of those clocks, and `bus_data` does not change while the strobe is high.
- R9: Between the start of the status byte and the start of the first payload byte there are BYTE_CLKS + GAP_CLKS clocks. No strobe is driven during the pause.
- R10: `pkg_rdy` rises with the first header byte and falls when the last payload byte period ends. While `pkg_rdy` is low, `bus_stb` and `bus_data` are 0.
- R11: Each word is fetched with a one-clock `rd_en` pulse, and exactly one pulse is issued per payload word. Pulses occur only inside a package. `rd_data` must be valid one clock after the pulse and held until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_tick | input | 1 | Start or realign the reporting cycle |
| mode_in | input | 8 | Mode byte, captured at each package start |
| status_in | input | 8 | Status byte, captured at each package start |
| rd_en | output | 1 | Result store read strobe |
| rd_addr | output | AW | Result store word address |
| rd_data | input | 16 | Result store read data, one clock latency |
| bus_data | output | 8 | Byte on the host bus |
| bus_stb | output | 1 | Byte strobe |
| pkg_rdy | output | 1 | High for the length of a package |
| pkg_id | output | $clog2(NUM_PKG+1) | Number of the current package |

## Verification
The bench runs one full reporting cycle and then the first slot of the next cycle. This checks the uneven slot pattern and the wrap from package 6 to 1. A scheduler that counted slots wrongly would start packages in the wrong clock, and a counter that failed to wrap would show id 7 or 0. It also measures the byte spacing around the header pause and the strobe width. A pacer off by one clock would move every payload byte and fail those checks, and a byte that changed too early would break the hold check. A second `cycle_tick` is sent in the middle of a cycle, in raw mode, and mode and status are changed right after that package starts. A design that sampled them late would send the new bytes in the header, and a design that ignored the mode would send register words instead of samples.

// File: rtl/meas_pkg_tx_pkg.sv
package meas_pkg_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_HDR,
    TX_GAP,
    TX_PAY
  } tx_state_e;

  // Even spreading of npkg launches over slots: slot s launches when a
  // multiple of slots lies in [s*npkg, s*npkg + npkg).
  function automatic bit slot_launches(input int s, input int slots, input int npkg);
    int r;
    r = (s * npkg) % slots;
    return (r == 0) || (r > (slots - npkg));
  endfunction

  // Register lookup: package number and word position to store address.
  function automatic int payload_index(input int pkg, input int word, input bit raw,
                                       input int rpp, input int npkg);
    if (raw) return npkg * rpp + word;
    return (pkg - 1) * rpp + word;
  endfunction

endpackage

// File: rtl/meas_pkg_slot_sched.sv
module meas_pkg_slot_sched
  import meas_pkg_tx_pkg::*;
#(
  parameter int SLOT_CLKS = 65536,
  parameter int SLOTS     = 10,
  parameter int NUM_PKG   = 6,
  parameter int PIDW      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cycle_tick,
  input  logic            busy,
  output logic            launch,
  output logic [PIDW-1:0] launch_id
);

  localparam int TW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic            armed;
  logic [TW-1:0]   tmr;
  logic [SW-1:0]   sidx;
  logic [SW-1:0]   sidx_nxt;
  logic [PIDW-1:0] pnum;
  logic [PIDW-1:0] pnum_base;
  logic [SLOTS-1:0] mask;
  logic            slot_start;

  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    assign mask[s] = slot_launches(s, SLOTS, NUM_PKG);
  end

  always_comb begin
    slot_start = cycle_tick | (armed & (tmr == TW'(SLOT_CLKS - 1)));
    if (cycle_tick)                    sidx_nxt = '0;
    else if (sidx == SW'(SLOTS - 1))   sidx_nxt = '0;
    else                               sidx_nxt = sidx + 1'b1;
    pnum_base = cycle_tick ? PIDW'(1) : pnum;
    launch    = slot_start & mask[sidx_nxt] & ~busy;
    launch_id = pnum_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      tmr   <= '0;
      sidx  <= '0;
      pnum  <= PIDW'(1);
    end else begin
      if (cycle_tick) armed <= 1'b1;
      if (slot_start) begin
        tmr  <= '0;
        sidx <= sidx_nxt;
      end else if (armed) begin
        tmr <= tmr + 1'b1;
      end
      if (launch)
        pnum <= (pnum_base == PIDW'(NUM_PKG)) ? PIDW'(1) : pnum_base + 1'b1;
      else
        pnum <= pnum_base;
    end
  end

endmodule

// File: rtl/meas_pkg_byte_pacer.sv
module meas_pkg_byte_pacer #(
  parameter int BYTE_CLKS = 45,
  parameter int STB_HI    = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic wrap,
  output logic stb_nxt
);

  localparam int CW = (BYTE_CLKS > 1) ? $clog2(BYTE_CLKS) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;

  always_comb begin
    wrap = run && (cnt == CW'(BYTE_CLKS - 1));
    if (start)     nxt = '0;
    else if (wrap) nxt = '0;
    else if (run)  nxt = cnt + 1'b1;
    else           nxt = cnt;
    stb_nxt = (nxt < CW'(STB_HI));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end

endmodule

// File: rtl/meas_pkg_seq.sv
module meas_pkg_seq
  import meas_pkg_tx_pkg::*;
#(
  parameter int          BYTE_CLKS    = 45,
  parameter int          STB_HI       = 22,
  parameter int          GAP_CLKS     = 450,
  parameter int          REGS_PER_PKG = 4,
  parameter int          RAW_WORDS    = 6,
  parameter int          NUM_PKG      = 6,
  parameter int          PIDW         = 3,
  parameter int          AW           = 5,
  parameter logic [15:0] SYNC_WORD    = 16'hC3A5,
  parameter logic [7:0]  RAW_MODE     = 8'h05
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic [PIDW-1:0] launch_id,
  input  logic [7:0]      mode_in,
  input  logic [7:0]      status_in,
  input  logic [15:0]     rd_data,
  output logic            busy,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  output logic [7:0]      bus_data,
  output logic            bus_stb,
  output logic            pkg_rdy,
  output logic [PIDW-1:0] pkg_id
);

  localparam int MAXW = (REGS_PER_PKG > RAW_WORDS) ? REGS_PER_PKG : RAW_WORDS;
  localparam int WW   = $clog2(MAXW + 1);
  localparam int GW   = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;

  tx_state_e     state;
  logic [1:0]    bidx;
  logic [WW-1:0] widx;
  logic          hi_sel;
  logic [GW-1:0] gcnt;
  logic [7:0]    mode_q;
  logic [7:0]    stat_q;
  logic          raw_q;
  logic [7:0]    hi_q;
  logic [7:0]    hdr_next;
  logic          accept;
  logic          gap_last;
  logic          last_word;
  logic          wrap;
  logic          stb_nxt;
  int            nw;

  function automatic logic [AW-1:0] word_addr(input int w);
    return AW'(payload_index(int'(pkg_id), w, raw_q, REGS_PER_PKG, NUM_PKG));
  endfunction

  always_comb begin
    busy      = (state != TX_IDLE);
    accept    = launch && (state == TX_IDLE);
    gap_last  = (state == TX_GAP) && (gcnt == GW'(GAP_CLKS - 1));
    nw        = raw_q ? RAW_WORDS : REGS_PER_PKG;
    last_word = (int'(widx) == nw - 1);
    case (bidx)
      2'd0:    hdr_next = SYNC_WORD[15:8];
      2'd1:    hdr_next = mode_q;
      default: hdr_next = stat_q;
    endcase
  end

  meas_pkg_byte_pacer #(
    .BYTE_CLKS(BYTE_CLKS),
    .STB_HI   (STB_HI)
  ) pacer_i (
    .clk    (clk),
    .rst    (rst),
    .start  (accept | gap_last),
    .run    ((state == TX_HDR) || (state == TX_PAY)),
    .wrap   (wrap),
    .stb_nxt(stb_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      bidx     <= '0;
      widx     <= '0;
      hi_sel   <= 1'b0;
      gcnt     <= '0;
      mode_q   <= '0;
      stat_q   <= '0;
      raw_q    <= 1'b0;
      hi_q     <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      bus_data <= '0;
      bus_stb  <= 1'b0;
      pkg_rdy  <= 1'b0;
      pkg_id   <= '0;
    end else begin
      rd_en <= 1'b0;
      case (state)
        TX_IDLE: begin
          if (accept) begin
            state    <= TX_HDR;
            bidx     <= '0;
            mode_q   <= mode_in;
            stat_q   <= status_in;
            raw_q    <= (mode_in == RAW_MODE);
            pkg_id   <= launch_id;
            bus_data <= SYNC_WORD[7:0];
            bus_stb  <= 1'b1;
            pkg_rdy  <= 1'b1;
          end
        end
        TX_HDR: begin
          bus_stb <= stb_nxt;
          if (wrap) begin
            if (bidx == 2'd3) begin
              state   <= TX_GAP;
              gcnt    <= '0;
              bus_stb <= 1'b0;
              rd_en   <= 1'b1;
              rd_addr <= word_addr(0);
            end else begin
              bidx     <= bidx + 1'b1;
              bus_data <= hdr_next;
            end
          end
        end
        TX_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gap_last) begin
            state    <= TX_PAY;
            widx     <= '0;
            hi_sel   <= 1'b0;
            bus_data <= rd_data[7:0];
            hi_q     <= rd_data[15:8];
            bus_stb  <= 1'b1;
          end
        end
        TX_PAY: begin
          bus_stb <= stb_nxt;
          if (wrap) begin
            if (!hi_sel) begin
              hi_sel   <= 1'b1;
              bus_data <= hi_q;
              if (!last_word) begin
                rd_en   <= 1'b1;
                rd_addr <= word_addr(int'(widx) + 1);
              end
            end else if (last_word) begin
              state    <= TX_IDLE;
              pkg_rdy  <= 1'b0;
              bus_stb  <= 1'b0;
              bus_data <= '0;
            end else begin
              widx     <= widx + 1'b1;
              hi_sel   <= 1'b0;
              bus_data <= rd_data[7:0];
              hi_q     <= rd_data[15:8];
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/meas_pkg_tx.sv
module meas_pkg_tx #(
  parameter int          SLOT_CLKS    = 65536,
  parameter int          SLOTS        = 10,
  parameter int          NUM_PKG      = 6,
  parameter int          BYTE_CLKS    = 45,
  parameter int          STB_HI       = 22,
  parameter int          GAP_CLKS     = 450,
  parameter int          REGS_PER_PKG = 4,
  parameter int          RAW_WORDS    = 6,
  parameter int          AW           = 5,
  parameter logic [15:0] SYNC_WORD    = 16'hC3A5,
  parameter logic [7:0]  RAW_MODE     = 8'h05,
  localparam int         PIDW         = $clog2(NUM_PKG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cycle_tick,
  input  logic [7:0]      mode_in,
  input  logic [7:0]      status_in,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  input  logic [15:0]     rd_data,
  output logic [7:0]      bus_data,
  output logic            bus_stb,
  output logic            pkg_rdy,
  output logic [PIDW-1:0] pkg_id
);

  logic            busy;
  logic            launch;
  logic [PIDW-1:0] launch_id;

  meas_pkg_slot_sched #(
    .SLOT_CLKS(SLOT_CLKS),
    .SLOTS    (SLOTS),
    .NUM_PKG  (NUM_PKG),
    .PIDW     (PIDW)
  ) sched_i (
    .clk       (clk),
    .rst       (rst),
    .cycle_tick(cycle_tick),
    .busy      (busy),
    .launch    (launch),
    .launch_id (launch_id)
  );

  meas_pkg_seq #(
    .BYTE_CLKS   (BYTE_CLKS),
    .STB_HI      (STB_HI),
    .GAP_CLKS    (GAP_CLKS),
    .REGS_PER_PKG(REGS_PER_PKG),
    .RAW_WORDS   (RAW_WORDS),
    .NUM_PKG     (NUM_PKG),
    .PIDW        (PIDW),
    .AW          (AW),
    .SYNC_WORD   (SYNC_WORD),
    .RAW_MODE    (RAW_MODE)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .launch_id(launch_id),
    .mode_in  (mode_in),
    .status_in(status_in),
    .rd_data  (rd_data),
    .busy     (busy),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .bus_data (bus_data),
    .bus_stb  (bus_stb),
    .pkg_rdy  (pkg_rdy),
    .pkg_id   (pkg_id)
  );

endmodule

// File: rtl/meas_pkg_tx_chk.sv
module meas_pkg_tx_chk #(
  parameter int NUM_PKG = 6,
  parameter int PIDW    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en,
  input logic [7:0]      bus_data,
  input logic            bus_stb,
  input logic            pkg_rdy,
  input logic [PIDW-1:0] pkg_id
);

  assert_stb_framed_R10: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> pkg_rdy);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && $past(bus_stb)) |-> $stable(bus_data));

  assert_rd_single_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  assert_rd_framed_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> pkg_rdy);

  assert_id_range_R4: assert property (@(posedge clk) disable iff (rst)
    pkg_rdy |-> ((pkg_id >= PIDW'(1)) && (pkg_id <= PIDW'(NUM_PKG))));

  assert_id_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pkg_rdy && $past(pkg_rdy)) |-> $stable(pkg_id));

endmodule

bind meas_pkg_tx meas_pkg_tx_chk #(
  .NUM_PKG(NUM_PKG),
  .PIDW   (PIDW)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .bus_data(bus_data),
  .bus_stb (bus_stb),
  .pkg_rdy (pkg_rdy),
  .pkg_id  (pkg_id)
);

// File: tb/meas_pkg_tx_tb_top.sv
`timescale 1ns/1ps
module meas_pkg_tx_tb_top;

  localparam int SLOT = 200;
  localparam int NSL  = 10;
  localparam int B    = 6;
  localparam int H    = 3;
  localparam int G    = 10;
  localparam int RPP  = 4;
  localparam int RAWW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cycle_tick = 1'b0;
  logic [7:0]  mode_in = 8'h00;
  logic [7:0]  status_in = 8'h00;
  logic        rd_en;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data = 16'h0000;
  logic [7:0]  bus_data;
  logic        bus_stb;
  logic        pkg_rdy;
  logic [2:0]  pkg_id;

  always #2 clk = ~clk;

  meas_pkg_tx #(
    .SLOT_CLKS(SLOT), .SLOTS(NSL), .NUM_PKG(6), .BYTE_CLKS(B), .STB_HI(H),
    .GAP_CLKS(G), .REGS_PER_PKG(RPP), .RAW_WORDS(RAWW), .AW(5)
  ) dut_i (
    .clk(clk), .rst(rst), .cycle_tick(cycle_tick), .mode_in(mode_in),
    .status_in(status_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_data(bus_data), .bus_stb(bus_stb), .pkg_rdy(pkg_rdy), .pkg_id(pkg_id)
  );

  function automatic logic [15:0] memval(input int a);
    logic [7:0] h, l;
    h = 8'(a + 48);
    l = 8'(a ^ 192);
    return {h, l};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= memval(int'(rd_addr));

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] bt [0:255];
  int bts [0:255];
  int ps [0:15], pe [0:15], pid [0:15];
  int nb = 0, np = 0, nrd = 0, stab_bad = 0, wid_bad = 0, idle_bad = 0, wcnt = 0;
  logic [7:0] cur = 8'h00;
  logic prev_stb = 1'b0, prev_rdy = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      prev_stb = 1'b0;
      prev_rdy = 1'b0;
    end else begin
      if (bus_stb && !prev_stb) begin
        bt[nb] = bus_data; bts[nb] = cyc; cur = bus_data; nb++; wcnt = 1;
      end else if (bus_stb && prev_stb) begin
        wcnt++;
        if (bus_data != cur) stab_bad++;
      end
      if (!bus_stb && prev_stb && wcnt != H) wid_bad++;
      if (pkg_rdy && !prev_rdy) begin ps[np] = cyc; pid[np] = int'(pkg_id); np++; end
      if (!pkg_rdy && prev_rdy && np > 0) pe[np-1] = cyc;
      if (rd_en) nrd++;
      if (!pkg_rdy && (bus_stb || bus_data != 8'h00)) idle_bad++;
      prev_stb = bus_stb;
      prev_rdy = pkg_rdy;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nb = 0; np = 0; nrd = 0; stab_bad = 0; wid_bad = 0; idle_bad = 0;
  endtask

  task automatic pulse_tick(output int t);
    @(negedge clk) cycle_tick = 1'b1;
    @(negedge clk) cycle_tick = 1'b0;
    t = cyc;
  endtask

  task automatic check_pkg(input int k, input int base, input int exp_id, input int t_exp,
                           input bit raw, input logic [7:0] md, input logic [7:0] st);
    int w;
    logic [15:0] v;
    w = raw ? RAWW : RPP;
    chk(pid[k] == exp_id, "R4 package id", pid[k], exp_id);
    chk(ps[k] == t_exp, "R3 launch cycle", ps[k], t_exp);
    chk(bts[base] == t_exp, "R10 ready with first byte", bts[base], t_exp);
    chk(bt[base] == 8'hA5, "R5 sync low", int'(bt[base]), 'hA5);
    chk(bt[base+1] == 8'hC3, "R5 sync high", int'(bt[base+1]), 'hC3);
    chk(bt[base+2] == md, "R5 mode byte", int'(bt[base+2]), int'(md));
    chk(bt[base+3] == st, "R5 status byte", int'(bt[base+3]), int'(st));
    for (int j = 0; j < w; j++) begin
      v = memval(raw ? (6 * RPP + j) : ((exp_id - 1) * RPP + j));
      chk(bt[base+4+2*j] == v[7:0], raw ? "R7 sample low" : "R6 word low",
          int'(bt[base+4+2*j]), int'(v[7:0]));
      chk(bt[base+5+2*j] == v[15:8], raw ? "R7 sample high" : "R6 word high",
          int'(bt[base+5+2*j]), int'(v[15:8]));
    end
    chk(bts[base+3] - bts[base] == 3 * B, "R8 header pacing", bts[base+3] - bts[base], 3 * B);
    chk(bts[base+4] - bts[base+3] == B + G, "R9 header pause",
        bts[base+4] - bts[base+3], B + G);
    chk(bts[base+3+2*w] - bts[base+4] == (2 * w - 1) * B, "R8 payload pacing",
        bts[base+3+2*w] - bts[base+4], (2 * w - 1) * B);
    chk(pe[k] == t_exp + 4 * B + G + 2 * w * B, "R10 ready end",
        pe[k], t_exp + 4 * B + G + 2 * w * B);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(bus_stb == 1'b0 && pkg_rdy == 1'b0 && rd_en == 1'b0, "R1 reset controls",
        int'({bus_stb, pkg_rdy, rd_en}), 0);
    chk(bus_data == 8'h00, "R1 reset data", int'(bus_data), 0);
    rst = 1'b0;
    clear_mon();
    repeat (3 * SLOT) @(negedge clk);
    chk(np == 0, "R1 no package before tick", np, 0);
    chk(nb == 0, "R1 no strobe before tick", nb, 0);
  endtask

  task automatic t_full_cycle();
    int t, k;
    int slots [0:6];
    k = 0;
    for (int s = 0; s < NSL; s++)
      if (((s * 6) % NSL) == 0 || ((s * 6) % NSL) > NSL - 6) begin slots[k] = s; k++; end
    slots[6] = NSL;
    mode_in = 8'h03; status_in = 8'h81;
    clear_mon();
    pulse_tick(t);
    repeat (NSL * SLOT + 150) @(negedge clk);
    chk(np == 7, "R3 packages in one cycle plus next slot 0", np, 7);
    chk(k == 6, "R3 launch slot count", k, 6);
    for (int i = 0; i < 7; i++)
      check_pkg(i, i * (4 + 2 * RPP), (i % 6) + 1, t + slots[i] * SLOT, 1'b0, 8'h03, 8'h81);
    chk(pid[6] == 1, "R4 wrap to 1", pid[6], 1);
    chk(nrd == 7 * RPP, "R11 read pulses per word", nrd, 7 * RPP);
    chk(stab_bad == 0, "R8 data held under strobe", stab_bad, 0);
    chk(wid_bad == 0, "R8 strobe width", wid_bad, 0);
    chk(idle_bad == 0, "R10 idle bus quiet", idle_bad, 0);
  endtask

  task automatic t_raw_retick();
    int t;
    mode_in = 8'h05; status_in = 8'h11;
    clear_mon();
    pulse_tick(t);
    repeat (30) @(negedge clk);
    status_in = 8'h22; mode_in = 8'h03;
    repeat (SLOT + 180) @(negedge clk);
    chk(np == 2, "R2 packages after mid-cycle tick", np, 2);
    chk(pid[0] == 1, "R2 restart at package 1", pid[0], 1);
    check_pkg(0, 0, 1, t, 1'b1, 8'h05, 8'h11);
    check_pkg(1, 4 + 2 * RAWW, 2, t + SLOT, 1'b0, 8'h03, 8'h22);
    chk(nrd == RAWW + RPP, "R11 read pulses raw and normal", nrd, RAWW + RPP);
    chk(stab_bad == 0 && wid_bad == 0, "R8 strobe shape in raw mode", stab_bad + wid_bad, 0);
    chk(idle_bad == 0, "R10 idle bus quiet after raw", idle_bad, 0);
  endtask

  initial begin
    t_reset();
    t_full_cycle();
    t_raw_retick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule